// File: doc/BRIEF.md
# Harmonic-Free Frequency Tracing Detector

This block decides whether a recovered half-rate clock runs slower than half the incoming bit rate. It needs two rising-edge events, each delivered as a one-cycle strobe from a fast sampling domain. One strobe marks a rising edge of the data and the other a rising edge of the recovered clock. When the clock runs at half the bit rate or faster, at least one clock edge falls between any two data rising edges. So when two data edges arrive with no clock edge between them, the clock is too slow. In that case the block raises an UP request toward a charge pump.

Tracing works without harmonic lock only if the oscillator starts from its lowest frequency. A band reset or discharge outside this block must therefore come before operation. The machine has four states: idle, armed, pending and pump. UP is decoded only from the pump state, which the machine reaches one cycle after the pending state. A clock edge that arrives during that pending cycle cancels the request, so a near-coincident edge pair never reaches the charge pump. UP is held for a programmable charging window. After the window the machine returns to the armed state, because a data edge has just been seen. Driving the enable input low holds the machine in idle.

Top module: `freq_trace_det`

## Requirements
- R1: While reset is asserted, and for the cycles until the internal synchronised reset is released, `state_o` is 0 (idle) and `up` is 0. State codes: 0 idle, 1 armed, 2 pending, 3 pump.
- R2: In idle with enable high, a data strobe without a clock strobe moves `state_o` to 1 (armed) on the next clock edge.
- R3: In armed, a clock strobe returns `state_o` to 0 on the next edge. This holds whether or not a data strobe arrives in the same cycle.
- R4: In armed, a data strobe without a clock strobe moves `state_o` to 2 (pending). One cycle later, if no clock strobe arrived in the pending cycle, `state_o` becomes 3 and `up` becomes 1.
- R5: In pending, a clock strobe returns `state_o` to 0, and `up` is not raised.
- R6: `up` is 1 exactly when `state_o` is 3. It stays high for exactly CHARGE_CYC consecutive cycles, after which `state_o` becomes 1 (armed).
- R7: Data and clock strobes arriving during the pump state have no effect: the state stays 3 and the window length is unchanged.
- R8: In idle, a data strobe and a clock strobe in the same cycle leave `state_o` at 0. The clock edge wins.
- R9: When enable is low at a clock edge, `state_o` becomes 0 and `up` becomes 0, whatever the strobes are. This also cuts short a charging window that is in progress.
- R10: If every data rising edge is followed by a clock edge before the next data edge, `up` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside the block |
| enable | input | 1 | Detector enable; when low, holds the machine in idle |
| data_rise | input | 1 | One-cycle strobe for a rising edge of the data |
| clk_rise | input | 1 | One-cycle strobe for a rising edge of the recovered clock |
| up | output | 1 | Speed-up request to the charge pump |
| state_o | output | 2 | Current state code (0 idle, 1 armed, 2 pending, 3 pump) |

## Verification
Alternating data and clock strobes stand for a clock at or above half rate. Back-to-back data strobes stand for a slow clock. Comparing the two shows that UP depends only on two data edges arriving with no clock edge between them. Directed sequences cover the following cases:
- a clock edge arriving in the pending cycle, which separates the glitch filter from the plain two-data-edge rule;
- coincident strobes, which show the clock edge taking priority;
- strobes arriving during the charging window, which the machine must ignore;
- enable dropping in the middle of a window.

Random strobe densities, both sparse and dense and with enable sometimes low, mix all of these transitions. A bench model checks every cycle against them.

// File: rtl/fte_pkg.sv
package fte_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_PENDING = 2'd2,
    ST_PUMP    = 2'd3
  } fte_state_e;
endpackage

// File: rtl/fte_rst_sync.sv
module fte_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = sh_q[STAGES-1];
endmodule

// File: rtl/fte_window.sv
module fte_window #(
  parameter int CHARGE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (CHARGE_CYC > 1) ? $clog2(CHARGE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CHARGE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (done) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == LAST);

  // Charging window counter never passes its last value (R6)
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // Counter restarts from zero whenever the window is not running (R6)
  assert_cnt_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/fte_next.sv
module fte_next
  import fte_pkg::*;
(
  input  fte_state_e state,
  input  logic       enable,
  input  logic       data_rise,
  input  logic       clk_rise,
  input  logic       win_done,
  output fte_state_e nxt
);
  always_comb begin
    nxt = state;
    if (!enable) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:    if (data_rise && !clk_rise) nxt = ST_ARMED;
        ST_ARMED:   if (clk_rise)       nxt = ST_IDLE;
                    else if (data_rise) nxt = ST_PENDING;
        ST_PENDING: if (clk_rise)       nxt = ST_IDLE;
                    else                nxt = ST_PUMP;
        ST_PUMP:    if (win_done)       nxt = ST_ARMED;
        default:    nxt = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/freq_trace_det.sv
module freq_trace_det
  import fte_pkg::*;
#(
  parameter int CHARGE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       data_rise,
  input  logic       clk_rise,
  output logic       up,
  output logic [1:0] state_o
);
  logic       rst_s;
  logic       win_done;
  fte_state_e state_q;
  fte_state_e state_d;

  fte_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  fte_window #(.CHARGE_CYC(CHARGE_CYC)) u_win (
    .clk   (clk),
    .rst_n (rst_s),
    .run   (state_q == ST_PUMP),
    .done  (win_done)
  );

  fte_next u_nxt (
    .state     (state_q),
    .enable    (enable),
    .data_rise (data_rise),
    .clk_rise  (clk_rise),
    .win_done  (win_done),
    .nxt       (state_d)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign up      = (state_q == ST_PUMP);
  assign state_o = state_q;

  // UP only ever follows a pending cycle (R4)
  assert_up_from_pending_R4: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(up) |-> $past(state_q) == ST_PENDING);
  // A clock edge in the pending cycle cancels the request (R5)
  assert_pending_cancel_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_PENDING && enable && clk_rise) |=> (!up && state_q == ST_IDLE));
  // End of a completed window lands in armed (R6)
  assert_window_end_R6: assert property (@(posedge clk) disable iff (!rst_s)
    ($fell(up) && $past(enable)) |-> state_q == ST_ARMED);
  // Armed plus clock edge goes idle (R3)
  assert_armed_clk_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_ARMED && enable && clk_rise) |=> state_q == ST_IDLE);
  // Coincident strobes in idle stay idle (R8)
  assert_coincide_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_IDLE && enable && clk_rise && data_rise) |=> state_q == ST_IDLE);
  // Disabled machine is idle with no request (R9)
  assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !enable |=> (state_q == ST_IDLE && !up));
endmodule

// File: tb/sim_freq_trace_det.sv
module sim_freq_trace_det;
  localparam int C = 4;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic       dr;
  logic       cr;
  logic       up;
  logic [1:0] st;

  int n_cmp;
  int n_bad;
  int m_st;
  int m_rem;
  bit done_flag;

  freq_trace_det #(.CHARGE_CYC(C)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (en),
    .data_rise (dr),
    .clk_rise  (cr),
    .up        (up),
    .state_o   (st)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_up(input int s);
    return (s == 3) ? 1 : 0;
  endfunction

  task automatic model_step(input logic e, input logic d, input logic c);
    if (!e) begin
      m_st = 0; m_rem = 0;
    end else begin
      case (m_st)
        0: if (d && !c) m_st = 1;
        1: if (c) m_st = 0; else if (d) m_st = 2;
        2: if (c) m_st = 0; else begin m_st = 3; m_rem = C; end
        default: if (m_rem == 1) m_st = 1; else m_rem = m_rem - 1;
      endcase
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input logic e, input logic d, input logic c, input string tag);
    en = e; dr = d; cr = c;
    model_step(e, d, c);
    @(negedge clk);
    check({tag, " state"}, int'(st), m_st);
    check({tag, " up"}, int'(up), exp_up(m_st));
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic e, d, c;
    n_cmp = 0; n_bad = 0; m_st = 0; m_rem = 0; done_flag = 1'b0;
    rst_n = 1'b0; en = 1'b1; dr = 1'b1; cr = 1'b0;
    void'($urandom(32'd7431));
    repeat (3) @(negedge clk);
    check("R1 reset state", int'(st), 0);
    check("R1 reset up", int'(up), 0);
    rst_n = 1'b1;
    repeat (3) step(1'b1, 1'b0, 1'b0, "R1 release");

    // R2 / R3
    step(1, 1, 0, "R2 idle->armed");
    step(1, 0, 0, "R2 hold armed");
    step(1, 0, 1, "R3 armed->idle");
    step(1, 1, 0, "R2 rearm");
    step(1, 1, 1, "R3 coincident in armed");

    // R4 / R6: slow clock
    step(1, 1, 0, "R4 arm");
    step(1, 1, 0, "R4 pending");
    for (int i = 0; i < C; i++) step(1, 0, 0, "R6 pump window");
    step(1, 0, 0, "R6 back armed");

    // R7: strobes during pump ignored
    step(1, 1, 0, "R4 pending again");
    step(1, 0, 0, "R4 enter pump");
    step(1, 1, 1, "R7 both strobes in pump");
    step(1, 0, 1, "R7 clock strobe in pump");
    step(1, 1, 0, "R7 data strobe in pump");
    step(1, 0, 0, "R7 window end");

    // R5: clock edge during pending cancels
    step(1, 0, 1, "R3 reset to idle");
    step(1, 1, 0, "R5 arm");
    step(1, 1, 0, "R5 pending");
    step(1, 0, 1, "R5 cancel");
    step(1, 0, 0, "R5 stays idle");

    // R8: coincident strobes in idle
    step(1, 1, 1, "R8 coincident idle");
    step(1, 0, 0, "R8 still idle");

    // R9: enable low
    step(1, 1, 0, "R9 arm");
    step(0, 1, 0, "R9 disable armed");
    step(0, 1, 0, "R9 strobes ignored");
    step(1, 1, 0, "R9 arm2");
    step(1, 1, 0, "R9 pending2");
    step(1, 0, 0, "R9 pump");
    step(0, 0, 0, "R9 cut window");

    // R10: fast clock never raises up
    for (int i = 0; i < 24; i++) begin
      step(1, 1, 0, "R10 data edge");
      step(1, 0, (i % 3) != 0, "R10 gap");
      step(1, 0, 1, "R10 clock edge");
    end

    // Random phases with different strobe densities
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 1500; i++) begin
        e = ($urandom % 16) != 0;
        d = ($urandom % 10) < (2 + 2 * ph);
        c = ($urandom % 10) < (5 - ph);
        step(e, d, c, "R4/R6 random");
      end
    end

    finish_run();
  end
endmodule